// File: doc/BRIEF.md
# Polyphase 4x Interpolation Filter

This block raises the sample rate of a 16-bit audio stream by four. A 44.1 kHz stream, for example, comes out at 176.4 kHz. The block also applies a fixed 32-tap lowpass filter whose stopband starts below 22.05 kHz. It gives the same result as inserting three zeros after every input sample and running the full filter at the high rate. It gets there with less work: the 32 coefficients are split into four phase sets of eight taps, and each output phase uses only its own set against the eight most recent real input samples. No multiply is spent on an inserted zero.

A single multiply-accumulate datapath walks the eight taps of one phase per output. Each input sample therefore produces four outputs, tagged with phase numbers 0 to 3, in rising phase order.

Both edges of the block are valid/ready streams. An input sample is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low from that acceptance until the fourth output of the sample has been taken. An output is taken on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the held output waits unchanged and no further phase is computed, so back-pressure stops the block completely.

Top module: `interp4_poly`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and all eight history entries are zero, so the outputs of the first samples see only zeros as older inputs.
- R2: `in_ready` is 0 from the cycle after an acceptance until the handshake of the phase-3 output, and it is 1 in the cycle after that handshake. A sample presented on `in_valid` during that interval is not taken and does not change any output.
- R3: Each accepted sample yields exactly four outputs, with `out_phase` equal to 0, 1, 2 and 3 in that order.
- R4: The value of phase k for input n is the zero-stuffed direct filter output y[4n+k] = sum over m of g[m]·u[4n+k−m]. Here u is the input stream with three zeros after each sample, and g[m] is the package table `coef_at(m)`: a symmetric 32-entry Q1.15 table with g[m] = g[31−m]. Phase k therefore uses taps g[4j+k] against x[n−j], for j = 0..7.
- R5: The accumulator keeps full precision. It is rounded by adding 2^14 and shifting right arithmetically by 15, then saturated to the range −32768..32767.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_phase` hold their values.
- R7: `out_valid` rises exactly 8 clock edges after the acceptance edge for phase 0, and exactly 8 edges after the previous output handshake for phases 1 to 3.
- R8: The history keeps the eight most recent accepted samples and shifts only on an acceptance, so an input stops affecting outputs once eight newer samples have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | 16 | Signed, rounded and saturated output sample |
| out_phase | output | 2 | Phase index k of the current output |

## Verification
The first output of a sample is due 8 edges after the acceptance edge, and each later phase is due 8 edges after the previous handshake. The bench counts falling edges from the edge it drove and requires `out_valid` on exactly the eighth. It reads every value and phase at the falling edge where `out_valid` is first seen, which is half a cycle after the register that drives them has settled. It also checks `in_ready` at every falling edge of the busy interval. When it holds `out_ready` low for a random number of cycles, it compares the held output at each of those falling edges before it completes the handshake.

// File: rtl/interp4_pkg.sv
package interp4_pkg;

  localparam int unsigned COEF_W    = 16;
  localparam int unsigned COEF_FRAC = 15;
  localparam int unsigned NTAPS     = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_HOLD = 2'd2
  } ctrl_state_e;

  // Symmetric lowpass prototype, Q1.15, windowed interpolation kernel.
  function automatic logic signed [COEF_W-1:0] coef_at(input int unsigned m);
    int unsigned f;
    f = (m < NTAPS / 2) ? m : (NTAPS - 1 - m);
    case (f)
      0:  return -16'sd52;
      1:  return -16'sd266;
      2:  return -16'sd571;
      3:  return -16'sd383;
      4:  return 16'sd555;
      5:  return 16'sd1836;
      6:  return 16'sd2434;
      7:  return 16'sd1315;
      8:  return -16'sd1661;
      9:  return -16'sd5041;
      10: return -16'sd6307;
      11: return -16'sd3336;
      12: return 16'sd4424;
      13: return 16'sd15268;
      14: return 16'sd25697;
      15: return 16'sd31933;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/interp4_history.sv
module interp4_history #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [DATA_W-1:0] rd_data
);

  logic signed [DATA_W-1:0] stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage[i] <= '0;
        end else if (shift_en) begin
          if (i == 0) stage[i] <= din;
          else        stage[i] <= stage[(i > 0) ? i - 1 : 0];
        end
      end
    end
  endgenerate

  assign rd_data = stage[rd_idx];

endmodule

// File: rtl/interp4_coef_rom.sv
module interp4_coef_rom #(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned NTAPS  = 32,
  parameter int unsigned IDX_W  = $clog2(NTAPS)
) (
  input  logic [IDX_W-1:0]         idx,
  output logic signed [COEF_W-1:0] coef
);

  logic signed [COEF_W-1:0] table_w [NTAPS];

  generate
    for (genvar i = 0; i < NTAPS; i++) begin : g_rom
      assign table_w[i] = COEF_W'(interp4_pkg::coef_at(i));
    end
  endgenerate

  assign coef = table_w[idx];

endmodule

// File: rtl/interp4_ctrl.sv
module interp4_ctrl #(
  parameter int unsigned PHASES  = 4,
  parameter int unsigned TAPS_PP = 8,
  parameter int unsigned PH_W    = $clog2(PHASES),
  parameter int unsigned TAP_W   = $clog2(TAPS_PP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             accept,
  output logic [TAP_W-1:0] tap_idx,
  output logic [PH_W-1:0]  phase_idx,
  output logic             mac_en,
  output logic             mac_first,
  output logic             mac_last,
  output logic             out_valid
);
  import interp4_pkg::*;

  localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(TAPS_PP - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASES - 1);

  ctrl_state_e      state_q;
  logic [TAP_W-1:0] tap_q;
  logic [PH_W-1:0]  phase_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign mac_en    = (state_q == ST_CALC);
  assign mac_first = (tap_q == '0);
  assign mac_last  = (tap_q == TAP_LAST);
  assign out_valid = (state_q == ST_HOLD);
  assign tap_idx   = tap_q;
  assign phase_idx = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      phase_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_CALC;
            tap_q   <= '0;
            phase_q <= '0;
          end
        end
        ST_CALC: begin
          if (mac_last) state_q <= ST_HOLD;
          else          tap_q   <= tap_q + 1'b1;
        end
        ST_HOLD: begin
          if (out_ready) begin
            tap_q <= '0;
            if (phase_q == PH_LAST) begin
              state_q <= ST_IDLE;
              phase_q <= '0;
            end else begin
              state_q <= ST_CALC;
              phase_q <= phase_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/interp4_mac.sv
module interp4_mac #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned COEF_W    = 16,
  parameter int unsigned TAPS_PP   = 8,
  parameter int unsigned COEF_FRAC = 15,
  parameter int unsigned ACC_W     = DATA_W + COEF_W + $clog2(TAPS_PP)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mac_en,
  input  logic                     mac_first,
  input  logic                     mac_last,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [DATA_W-1:0] result
);

  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1) <<< (COEF_FRAC - 1);
  localparam int unsigned HI_W = ACC_W - DATA_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  sum;
  logic signed [ACC_W-1:0]  rounded;
  logic signed [ACC_W-1:0]  scaled;
  logic [HI_W-1:0]          hi_bits;
  logic signed [DATA_W-1:0] sat_val;
  logic signed [DATA_W-1:0] result_q;

  assign prod     = sample * coef;
  assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
  assign sum      = (mac_first ? '0 : acc_q) + prod_ext;
  assign rounded  = sum + RND_HALF;
  assign scaled   = rounded >>> COEF_FRAC;
  assign hi_bits  = scaled[ACC_W-1:DATA_W-1];

  always_comb begin
    if ((&hi_bits) || !(|hi_bits)) begin
      sat_val = scaled[DATA_W-1:0];
    end else if (scaled[ACC_W-1]) begin
      sat_val = {1'b1, {(DATA_W - 1){1'b0}}};
    end else begin
      sat_val = {1'b0, {(DATA_W - 1){1'b1}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      result_q <= '0;
    end else if (mac_en) begin
      acc_q <= sum;
      if (mac_last) result_q <= sat_val;
    end
  end

  assign result = result_q;

endmodule

// File: rtl/interp4_poly.sv
module interp4_poly #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned COEF_W    = interp4_pkg::COEF_W,
  parameter int unsigned PHASES    = 4,
  parameter int unsigned TAPS_PP   = 8,
  parameter int unsigned COEF_FRAC = interp4_pkg::COEF_FRAC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DATA_W-1:0]         out_data,
  output logic [$clog2(PHASES)-1:0] out_phase
);

  localparam int unsigned NTAPS  = PHASES * TAPS_PP;
  localparam int unsigned PH_W   = $clog2(PHASES);
  localparam int unsigned TAP_W  = $clog2(TAPS_PP);
  localparam int unsigned CIDX_W = $clog2(NTAPS);

  logic                     accept;
  logic [TAP_W-1:0]         tap_idx;
  logic [PH_W-1:0]          phase_idx;
  logic                     mac_en, mac_first, mac_last;
  logic signed [DATA_W-1:0] hist_word;
  logic signed [COEF_W-1:0] coef_word;
  logic [CIDX_W-1:0]        coef_idx;
  logic signed [DATA_W-1:0] result;

  interp4_ctrl #(.PHASES(PHASES), .TAPS_PP(TAPS_PP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .accept(accept), .tap_idx(tap_idx),
    .phase_idx(phase_idx), .mac_en(mac_en), .mac_first(mac_first),
    .mac_last(mac_last), .out_valid(out_valid)
  );

  interp4_history #(.DATA_W(DATA_W), .DEPTH(TAPS_PP)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_data),
    .rd_idx(tap_idx), .rd_data(hist_word)
  );

  // Phase k, tap j reads prototype coefficient g[j*PHASES + k].
  assign coef_idx = CIDX_W'(tap_idx) * CIDX_W'(PHASES) + CIDX_W'(phase_idx);

  interp4_coef_rom #(.COEF_W(COEF_W), .NTAPS(NTAPS)) u_rom (
    .idx(coef_idx), .coef(coef_word)
  );

  interp4_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS_PP(TAPS_PP), .COEF_FRAC(COEF_FRAC)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .mac_first(mac_first),
    .mac_last(mac_last), .sample(hist_word), .coef(coef_word), .result(result)
  );

  assign out_data  = result;
  assign out_phase = phase_idx;

endmodule

// File: rtl/interp4_poly_chk.sv
module interp4_poly_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PHASES  = 4,
  parameter int unsigned TAPS_PP = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [DATA_W-1:0]         out_data,
  input logic [$clog2(PHASES)-1:0] out_phase
);

  localparam int unsigned PH_W = $clog2(PHASES);

  logic [7:0]      gap_cnt;
  logic [PH_W-1:0] exp_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt   <= '0;
      exp_phase <= '0;
    end else begin
      if ((in_valid && in_ready) || (out_valid && out_ready)) gap_cnt <= '0;
      else if (gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 1'b1;
      if (in_valid && in_ready) exp_phase <= '0;
      else if (out_valid && out_ready) exp_phase <= exp_phase + 1'b1;
    end
  end

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_phase)));

  assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_release_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_phase == PH_W'(PHASES - 1)) |=> in_ready);

  assert_phase_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_phase == exp_phase));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (gap_cnt == 8'(TAPS_PP)));

endmodule

bind interp4_poly interp4_poly_chk #(
  .DATA_W(DATA_W), .PHASES(PHASES), .TAPS_PP(TAPS_PP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_phase(out_phase)
);

// File: tb/sim_interp4_poly.sv
module sim_interp4_poly;
  import interp4_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic [1:0]  out_phase;

  int n_chk = 0;
  int n_fail = 0;
  int zs [32];
  int vals [48];

  always #4 clk = ~clk;

  interp4_poly u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_phase(out_phase)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int round_sat(input longint acc);
    longint r;
    r = (acc + 64'sd16384) >>> 15;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  // Zero-stuffed high-rate stream, zs[0] newest.
  task automatic zs_push(input int v);
    for (int i = 31; i > 0; i--) zs[i] = zs[i-1];
    zs[0] = v;
  endtask

  function automatic int direct_fir();
    longint acc = 0;
    for (int m = 0; m < 32; m++) acc += longint'(coef_at(m)) * longint'(zs[m]);
    return round_sat(acc);
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 32; i++) zs[i] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  // Entered at a falling edge; returns at a falling edge after the 4th handshake.
  task automatic do_sample(input int x, input int next_x, input bit eager,
                           input bit stall, input string tag);
    int cnt, exp;
    bit busy_ok;
    logic [15:0] hd;
    logic [1:0]  hp;
    in_data = 16'(x); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = eager;            // next sample offered early: must wait (R2)
    in_data  = 16'(next_x);
    zs_push(x);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) zs_push(0);
      exp = direct_fir();
      cnt = 0; busy_ok = 1'b1;
      while (!out_valid && cnt < 100) begin
        if (in_ready) busy_ok = 1'b0;
        cnt++;
        @(negedge clk);
      end
      chk(cnt == 8, "R7", "edges until out_valid", cnt, 8);
      chk(busy_ok && !in_ready, "R2", "in_ready low while busy", int'(in_ready), 0);
      chk(out_phase == 2'(k), "R3", "phase order", int'(out_phase), k);
      chk(int'($signed(out_data)) == exp, tag, "output value",
          int'($signed(out_data)), exp);
      if (stall) begin
        hd = out_data; hp = out_phase;
        repeat (1 + ($urandom % 3)) begin
          @(negedge clk);
          chk(out_valid && out_data == hd && out_phase == hp, "R6",
              "held output under stall", int'($signed(out_data)), int'($signed(hd)));
        end
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(in_ready == 1'b1, "R2", "in_ready after phase 3", int'(in_ready), 1);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // Impulse, then 8 zeros: the impulse leaves the history after 8 samples (R8).
    do_sample(32767, 0, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 8; i++) do_sample(0, 0, 1'b0, 1'b0, "R8");

    // Full-scale steps drive every phase into saturation (R5).
    for (int i = 0; i < 9; i++) do_sample(32767, 32767, 1'b1, 1'b0, "R5");
    for (int i = 0; i < 9; i++) do_sample(-32768, -32768, 1'b0, 1'b1, "R5");
    for (int i = 0; i < 6; i++)
      do_sample((i % 2) ? -32768 : 32767, 0, 1'b0, 1'b0, "R5");

    // Reset mid-stream clears the history (R1).
    do_reset();
    do_sample(-20000, 0, 1'b0, 1'b0, "R1");

    // Random stream with early offers and random stalls (R4).
    for (int i = 0; i < 48; i++) vals[i] = int'($signed(16'($urandom)));
    for (int i = 0; i < 48; i++)
      do_sample(vals[i], (i < 47) ? vals[i+1] : 0, (i < 47) && ($urandom % 2 == 1),
                ($urandom % 3 == 0), "R4");

    in_valid = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule